// File: doc/BRIEF.md
# Three-Floor Elevator Move Controller

This block steers an elevator car that serves three floors. It holds the floor where the car stands as its state. On every clock it looks at three call inputs, one for each floor, and raises exactly one of five move outputs. The outputs give a signed distance: two floors down, one floor down, stay, one floor up, or two floors up. After the edge that serves a call, the held floor equals the floor that was called.

A single parameter picks one of two variants, and both have the same ports. The Mealy variant computes the move directly from the held floor and the present calls, so the move appears in the same cycle as the call. The Moore variant registers the move together with the floor, so its outputs depend on state only and show the move one clock after the call. When several calls are raised at once, the lowest floor is served. When no call is raised, the car stays where it is.

Top module: `elev_move_ctrl`

## Requirements
- R1: While `rst` (asynchronous, active high) is asserted, the held floor is 1. In the Moore variant the stay output is high. The Mealy variant outputs stay while no call is raised. After release, the first call is measured from floor 1.
- R2: In every cycle exactly one of `go_dn2`, `go_dn1`, `go_stay`, `go_up1`, `go_up2` is high, in both variants.
- R3: In the Mealy variant the move equals the target floor minus the held floor, in the same cycle as the call. A distance of -2 gives `go_dn2`, -1 gives `go_dn1`, 0 gives `go_stay`, +1 gives `go_up1` and +2 gives `go_up2`.
- R4: With no call raised, the output is stay and the held floor does not change.
- R5: When several calls are raised, the lowest-numbered floor among them is the target.
- R6: At the clock edge, the held floor becomes the target floor. The held floor always stays in the range 1 to 3.
- R7: In the Moore variant the outputs show the move computed at the previous clock edge. They do not react to calls that change between edges.
- R8: A call for the floor the car already holds gives stay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| call_f1 | input | 1 | Call for floor 1 |
| call_f2 | input | 1 | Call for floor 2 |
| call_f3 | input | 1 | Call for floor 3 |
| go_dn2 | output | 1 | Move down two floors |
| go_dn1 | output | 1 | Move down one floor |
| go_stay | output | 1 | No movement |
| go_up1 | output | 1 | Move up one floor |
| go_up2 | output | 1 | Move up two floors |

## Verification
In the Mealy variant the move is due in the same cycle as the call. The bench drives calls just after a rising edge and samples at the following falling edge, before the floor register has taken the target. In the Moore variant the move is due one edge later. For that variant the bench keeps the move it predicted in the previous cycle and compares the outputs with it at the next falling edge, while new calls are already applied. This also shows that the Moore outputs ignore calls that arrive between edges.

// File: rtl/elev_pkg.sv
package elev_pkg;
  localparam int NUM_FLOORS = 3;
  localparam int FLOOR_W = $clog2(NUM_FLOORS + 1);
  localparam int NUM_MOVES = 2 * (NUM_FLOORS - 1) + 1;
  localparam int MOVE_W = $clog2(NUM_MOVES);

  typedef logic [FLOOR_W-1:0] floor_t;

  // code = distance + 2, so the order of the codes is the order of the distances
  typedef enum logic [MOVE_W-1:0] {
    MV_DN2  = 3'd0,
    MV_DN1  = 3'd1,
    MV_HOLD = 3'd2,
    MV_UP1  = 3'd3,
    MV_UP2  = 3'd4
  } move_t;

  localparam floor_t HOME_FLOOR = floor_t'(1);

  // the lowest raised call wins; with no call the car keeps its floor
  function automatic floor_t pick_target(logic [NUM_FLOORS-1:0] calls, floor_t cur);
    floor_t t;
    t = cur;
    for (int i = NUM_FLOORS - 1; i >= 0; i--)
      if (calls[i]) t = floor_t'(i + 1);
    return t;
  endfunction

  // signed distance with an offset, kept non-negative
  function automatic move_t move_of(floor_t tgt, floor_t cur);
    logic [MOVE_W-1:0] s;
    s = MOVE_W'(tgt) + MOVE_W'(NUM_FLOORS - 1) - MOVE_W'(cur);
    return move_t'(s);
  endfunction
endpackage

// File: rtl/elev_target_sel.sv
module elev_target_sel
  import elev_pkg::*;
(
  input  logic [NUM_FLOORS-1:0] calls,
  input  floor_t                cur_floor,
  output floor_t                tgt_floor,
  output logic                  call_any
);
  assign tgt_floor = pick_target(calls, cur_floor);
  assign call_any  = |calls;
endmodule

// File: rtl/elev_mealy_core.sv
module elev_mealy_core
  import elev_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  floor_t tgt_floor,
  input  logic   call_any,
  output floor_t cur_floor,
  output move_t  move
);
  floor_t floor_q;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) floor_q <= HOME_FLOOR;
    else     floor_q <= tgt_floor;
  end

  assign cur_floor = floor_q;
  assign move      = move_of(tgt_floor, floor_q);

  assert_floor_range_R6: assert property (@(posedge clk) disable iff (rst)
    (floor_q >= floor_t'(1)) && (floor_q <= floor_t'(NUM_FLOORS)));

  assert_idle_stays_R4: assert property (@(posedge clk) disable iff (rst)
    !call_any |=> $stable(floor_q));

  assert_idle_holds_R4: assert property (@(posedge clk) disable iff (rst)
    !call_any |-> move == MV_HOLD);

  assert_reset_home_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> floor_q == HOME_FLOOR);
endmodule

// File: rtl/elev_moore_core.sv
module elev_moore_core
  import elev_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  floor_t tgt_floor,
  input  logic   call_any,
  output floor_t cur_floor,
  output move_t  move
);
  floor_t floor_q;
  move_t  move_q;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      floor_q <= HOME_FLOOR;
      move_q  <= MV_HOLD;
    end else begin
      floor_q <= tgt_floor;
      move_q  <= move_of(tgt_floor, floor_q);
    end
  end

  assign cur_floor = floor_q;
  assign move      = move_q;

  assert_idle_then_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !call_any |=> move_q == MV_HOLD);

  assert_move_lags_R7: assert property (@(posedge clk) disable iff (rst)
    (tgt_floor != floor_q) |=> move_q != MV_HOLD);

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (floor_q == HOME_FLOOR) && (move_q == MV_HOLD));

  assert_floor_range_R6: assert property (@(posedge clk) disable iff (rst)
    (floor_q >= floor_t'(1)) && (floor_q <= floor_t'(NUM_FLOORS)));
endmodule

// File: rtl/elev_move_onehot.sv
module elev_move_onehot
  import elev_pkg::*;
(
  input  move_t              move,
  output logic [NUM_MOVES-1:0] lines
);
  for (genvar i = 0; i < NUM_MOVES; i++) begin : g_line
    assign lines[i] = (move == move_t'(i));
  end
endmodule

// File: rtl/elev_move_ctrl.sv
module elev_move_ctrl
  import elev_pkg::*;
#(
  parameter bit IS_MOORE = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic call_f1,
  input  logic call_f2,
  input  logic call_f3,
  output logic go_dn2,
  output logic go_dn1,
  output logic go_stay,
  output logic go_up1,
  output logic go_up2
);
  logic [NUM_FLOORS-1:0] calls;
  floor_t                cur_floor;
  floor_t                tgt_floor;
  logic                  call_any;
  move_t                 move;
  logic [NUM_MOVES-1:0]  lines;

  assign calls = {call_f3, call_f2, call_f1};

  elev_target_sel u_sel (
    .calls     (calls),
    .cur_floor (cur_floor),
    .tgt_floor (tgt_floor),
    .call_any  (call_any)
  );

  if (IS_MOORE) begin : g_moore
    elev_moore_core u_core (
      .clk (clk), .rst (rst), .tgt_floor (tgt_floor), .call_any (call_any),
      .cur_floor (cur_floor), .move (move)
    );
  end else begin : g_mealy
    elev_mealy_core u_core (
      .clk (clk), .rst (rst), .tgt_floor (tgt_floor), .call_any (call_any),
      .cur_floor (cur_floor), .move (move)
    );
  end

  elev_move_onehot u_dec (
    .move  (move),
    .lines (lines)
  );

  assign go_dn2  = lines[0];
  assign go_dn1  = lines[1];
  assign go_stay = lines[2];
  assign go_up1  = lines[3];
  assign go_up2  = lines[4];

  assert_one_move_R2: assert property (@(posedge clk) disable iff (rst)
    $countones({go_dn2, go_dn1, go_stay, go_up1, go_up2}) == 1);

  assert_low_call_wins_R5: assert property (@(posedge clk) disable iff (rst)
    call_f1 |=> cur_floor == floor_t'(1));
endmodule

// File: tb/elev_move_ctrl_test.sv
module elev_move_ctrl_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] req = 3'b000;   // {floor3, floor2, floor1}
  logic [4:0] ma, mo;         // bit0 = dn2 ... bit4 = up2
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  int mdl_floor = 1;
  int moore_code = 2;

  always #5 clk = ~clk;

  elev_move_ctrl uut (
    .clk(clk), .rst(rst), .call_f1(req[0]), .call_f2(req[1]), .call_f3(req[2]),
    .go_dn2(ma[0]), .go_dn1(ma[1]), .go_stay(ma[2]), .go_up1(ma[3]), .go_up2(ma[4])
  );

  elev_move_ctrl #(.IS_MOORE(1'b1)) uut_moore (
    .clk(clk), .rst(rst), .call_f1(req[0]), .call_f2(req[1]), .call_f3(req[2]),
    .go_dn2(mo[0]), .go_dn1(mo[1]), .go_stay(mo[2]), .go_up1(mo[3]), .go_up2(mo[4])
  );

  function automatic int exp_tgt(logic [2:0] r, int f);
    if (r[0]) return 1;
    if (r[1]) return 2;
    if (r[2]) return 3;
    return f;
  endfunction

  function automatic int exp_code(int t, int f);
    return (t - f) + 2;
  endfunction

  task automatic check(string tag, logic [4:0] got, int code);
    logic [4:0] want;
    want = 5'(1 << code);
    checks++;
    if (got !== want) begin
      fails++;
      $display("FAIL %s: got %b expected %b", tag, got, want);
    end
  endtask

  task automatic step(logic [2:0] r, string tag);
    int t, c;
    @(posedge clk);
    #1 req = r;
    @(negedge clk);
    t = exp_tgt(r, mdl_floor);
    c = exp_code(t, mdl_floor);
    check({tag, " R2 R3 mealy"}, ma, c);
    check("R7 moore lag", mo, moore_code);
    mdl_floor = t;
    moore_code = c;
  endtask

  task automatic pulse_reset();
    @(posedge clk);
    #1 begin req = 3'b000; rst = 1'b1; end
    @(negedge clk);
    check("R1 mealy in reset", ma, 2);
    check("R1 moore in reset", mo, 2);
    @(posedge clk);
    #1 rst = 1'b0;
    mdl_floor = 1;
    moore_code = 2;
  endtask

  initial begin
    void'($urandom(32'h00E1E7A7));
    repeat (2) @(negedge clk);
    check("R1 mealy reset", ma, 2);
    check("R1 moore reset", mo, 2);
    @(posedge clk);
    #1 rst = 1'b0;
    step(3'b000, "R4 idle");
    step(3'b100, "R1 first from floor 1");
    step(3'b100, "R8 same floor");
    step(3'b001, "R6 down two");
    step(3'b010, "R6 up one");
    step(3'b101, "R5 lowest of 1,3");
    step(3'b110, "R5 lowest of 2,3");
    step(3'b111, "R5 all three");
    step(3'b000, "R4 idle");
    step(3'b001, "R8 same floor");
    step(3'b100, "R3 up two");
    step(3'b010, "R3 down one");
    pulse_reset();
    step(3'b010, "R1 after reset");
    for (int i = 0; i < 300; i++) begin
      logic [2:0] r;
      r = (($urandom % 4) == 0) ? 3'b000 : 3'($urandom);
      step(r, "R3 random");
      if (i == 150) pulse_reset();
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule